// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Completion Interrupts

This block is a full-duplex asynchronous serial port. It has one transmitter and one receiver, both set by a single 8-bit mode register. Software turns each direction on separately. A byte written to the transmit register is serialised onto `txd`. The receiver watches `rxd`, rebuilds each incoming byte and stores it in a receive register that software can read. Both directions are timed by an external tick, `baud_tick`, that pulses 16 times per bit period.

Every frame has the same layout. It starts with one low start bit. The eight character bits follow, least significant bit first. Then comes an optional parity bit, which can be even, odd or forced to zero. The frame ends with one or two high stop bits.

Each finished transmit frame gives a one-cycle `tx_irq` pulse. Each finished receive frame gives a one-cycle `rx_irq` pulse. The receiver reports parity, framing and overrun errors through sticky flags. A received byte is always stored, even when its frame had an error. One mode bit can hold back `rx_irq` for any frame that had an error.

Mode register fields, written through `mode_wr`/`mode_din`:

| Bit(s) | Meaning |
|---|---|
| 7 | transmit enable |
| 6 | receive enable |
| 5:4 | parity: 00 none, 01 forced zero, 10 even, 11 odd |
| 2 | stop bits: 0 one, 1 two |
| 1 | suppress `rx_irq` on errored frames |

Bits 3 and 0 are ignored.

Transmitter states:

| State | Line level | Leaves when | Next state |
|---|---|---|---|
| TX_IDLE | high | a byte is held and transmit is enabled | TX_START |
| TX_START | low | the bit ends | TX_DATA |
| TX_DATA | bit being sent | the 8th bit ends | TX_PARITY, or TX_STOP1 when parity is none |
| TX_PARITY | parity bit | the bit ends | TX_STOP1 |
| TX_STOP1 | high | the bit ends | TX_STOP2 in two-stop mode, otherwise TX_IDLE |
| TX_STOP2 | high | the bit ends | TX_IDLE |

Receiver states:

| State | Leaves when | Next state |
|---|---|---|
| RX_IDLE | the synchronised line is low and receive is enabled | RX_START |
| RX_START | at the 8th tick: line still low | RX_DATA |
| RX_START | at the 8th tick: line high again (glitch) | RX_IDLE |
| RX_DATA | each bit is sampled every 16 ticks; after the 8th | RX_PARITY, or RX_STOP when parity is none |
| RX_PARITY | the bit is sampled | RX_STOP |
| RX_STOP | the first stop bit is sampled and the frame completes | RX_IDLE |

Clearing receive enable sends the receiver back to RX_IDLE from any state.

Top module: `uart_xcvr`

## Requirements
- R1: `txd` is high whenever no frame is being sent. A transmit write while bit 7 of the mode register is 0 is ignored and sends nothing.
- R2: A transmitted frame is one low start bit, then data bits D0 to D7, then a parity bit chosen by bits 5:4, then one or two high stop bits chosen by bit 2. Each bit lasts 16 `baud_tick` pulses. The parity bit is the XOR of the data in even mode, its inverse in odd mode, 0 in zero mode, and absent in none mode.
- R3: `tx_irq` is a one-cycle pulse. It comes after the last stop bit of each transmitted frame, never during that stop bit.
- R4: A transmit write made while a frame is being sent is held. That byte is sent as the next frame, right after the current one ends.
- R5: While bit 6 of the mode register is 0, frames on `rxd` are ignored. `rx_data` and `rx_irq` do not change.
- R6: The receiver samples each bit at its centre (16x oversampling). After each frame it loads the byte into `rx_data` and pulses `rx_irq` for one cycle.
- R7: A low pulse on `rxd` shorter than half a bit is rejected as a glitch and gives no frame. A valid frame that follows is still received.
- R8: `err_parity` is set when the received parity bit does not match the selected mode. A correct parity bit leaves it clear.
- R9: `err_frame` is set when the first stop bit samples low. In two-stop mode the second stop bit is not checked.
- R10: `err_overrun` is set when a frame completes while the previous byte has not yet been read with `rx_rd`.
- R11: An errored frame's byte is still loaded into `rx_data`. With mode bit 1 at 0 the frame still pulses `rx_irq`; with it at 1, no `rx_irq` is raised for that frame.
- R12: The error flags stay set until `err_clr` is pulsed. A later good frame does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Single-cycle pulse, 16 per bit period |
| mode_wr | input | 1 | Load the mode register from `mode_din` |
| mode_din | input | 8 | New mode register value |
| tx_wr | input | 1 | Write `tx_din` to the transmit register |
| tx_din | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Software has read `rx_data` |
| err_clr | input | 1 | Clear all error flags |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| tx_irq | output | 1 | Transmit-complete pulse |
| rx_irq | output | 1 | Receive-complete pulse |
| rx_data | output | 8 | Last received byte |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |

## Verification
The assertions check these rules on every cycle:
- `txd` is high whenever the transmitter is idle.
- Both interrupts last exactly one cycle.
- `tx_irq` arrives with the line already back high.
- A suppressed-mode `rx_irq` is never followed by a newly raised error flag.
- The flags stay set until `err_clr`.

The bench scenarios cover what depends on whole frames:
- bit order, parity values and stop-bit count on `txd`, decoded at bit centres;
- the held second byte;
- glitch rejection;
- the data stored from errored frames;
- the missing interrupt for a suppressed errored frame;
- overrun after two unread frames;
- frames ignored while reception is disabled.

// File: rtl/uart_xcvr_pkg.sv
package uart_xcvr_pkg;

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_ZERO = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } parity_e;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PARITY,
        TX_STOP1,
        TX_STOP2
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

    // Parity bit for a mode, given the XOR reduction of the data bits.
    function automatic logic par_bit(parity_e mode, logic data_xor);
        logic b;
        unique case (mode)
            PAR_EVEN: b = data_xor;
            PAR_ODD:  b = ~data_xor;
            default:  b = 1'b0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/uart_tx.sv
module uart_tx
    import uart_xcvr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable,
    input  logic              wr,
    input  logic [DATA_W-1:0] din,
    input  parity_e           par_mode,
    input  logic              two_stop,
    output logic              txd,
    output logic              done,
    output logic              busy
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W);

    tx_state_e          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [BIT_W-1:0]   bit_q;
    logic [DATA_W-1:0]  shreg_q;
    logic [DATA_W-1:0]  hold_q;
    logic               hold_vld_q;
    parity_e            par_q;
    logic               two_q;
    logic               pbit_q;
    logic               bit_end;
    logic               last_bit;
    logic               load;

    assign bit_end  = tick && (cnt_q == CNT_W'(OVS - 1));
    assign last_bit = (bit_q == BIT_W'(DATA_W - 1));
    assign load     = (state_q == TX_IDLE) && hold_vld_q && enable;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:   if (load) state_d = TX_START;
            TX_START:  if (bit_end) state_d = TX_DATA;
            TX_DATA:   if (bit_end && last_bit)
                           state_d = (par_q != PAR_NONE) ? TX_PARITY : TX_STOP1;
            TX_PARITY: if (bit_end) state_d = TX_STOP1;
            TX_STOP1:  if (bit_end) state_d = two_q ? TX_STOP2 : TX_IDLE;
            TX_STOP2:  if (bit_end) state_d = TX_IDLE;
            default:   state_d = TX_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= TX_IDLE;
            cnt_q      <= '0;
            bit_q      <= '0;
            shreg_q    <= '0;
            hold_q     <= '0;
            hold_vld_q <= 1'b0;
            par_q      <= PAR_NONE;
            two_q      <= 1'b0;
            pbit_q     <= 1'b0;
            done       <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= bit_end && (((state_q == TX_STOP1) && !two_q) ||
                                   (state_q == TX_STOP2));
            if (state_q == TX_IDLE) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= bit_end ? '0 : cnt_q + 1'b1;
            end
            if (load) begin
                shreg_q <= hold_q;
                bit_q   <= '0;
                par_q   <= par_mode;
                two_q   <= two_stop;
                pbit_q  <= par_bit(par_mode, ^hold_q);
            end else if ((state_q == TX_DATA) && bit_end) begin
                shreg_q <= shreg_q >> 1;
                bit_q   <= bit_q + 1'b1;
            end
            if (load) begin
                hold_vld_q <= 1'b0;
            end
            if (wr && enable) begin
                hold_q     <= din;
                hold_vld_q <= 1'b1;
            end
        end
    end

    // Output logic
    always_comb begin
        unique case (state_q)
            TX_START:  txd = 1'b0;
            TX_DATA:   txd = shreg_q[0];
            TX_PARITY: txd = pbit_q;
            default:   txd = 1'b1;
        endcase
    end

    assign busy = (state_q != TX_IDLE);

endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_xcvr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable,
    input  logic              rxd_raw,
    input  parity_e           par_mode,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W);
    localparam int MID   = OVS / 2 - 1;

    rx_state_e          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [BIT_W-1:0]   bit_q;
    logic [DATA_W-1:0]  shreg_q;
    logic [1:0]         sync_q;
    logic               rxs;
    parity_e            par_q;
    logic               perr_acc_q;
    logic               mid_hit;
    logic               ctr_hit;
    logic               last_bit;

    assign rxs      = sync_q[1];
    assign mid_hit  = tick && (cnt_q == CNT_W'(MID));
    assign ctr_hit  = tick && (cnt_q == CNT_W'(OVS - 1));
    assign last_bit = (bit_q == BIT_W'(DATA_W - 1));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (enable && !rxs) state_d = RX_START;
            RX_START:  if (mid_hit) state_d = rxs ? RX_IDLE : RX_DATA;
            RX_DATA:   if (ctr_hit && last_bit)
                           state_d = (par_q != PAR_NONE) ? RX_PARITY : RX_STOP;
            RX_PARITY: if (ctr_hit) state_d = RX_STOP;
            RX_STOP:   if (ctr_hit) state_d = RX_IDLE;
            default:   state_d = RX_IDLE;
        endcase
        if (!enable) begin
            state_d = RX_IDLE;
        end
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= RX_IDLE;
            sync_q     <= 2'b11;
            cnt_q      <= '0;
            bit_q      <= '0;
            shreg_q    <= '0;
            par_q      <= PAR_NONE;
            perr_acc_q <= 1'b0;
        end else begin
            state_q <= state_d;
            sync_q  <= {sync_q[0], rxd_raw};
            if (state_d != state_q) begin
                cnt_q <= '0;
            end else if (tick) begin
                cnt_q <= ctr_hit ? '0 : cnt_q + 1'b1;
            end
            if (state_q == RX_IDLE) begin
                bit_q      <= '0;
                par_q      <= par_mode;
                perr_acc_q <= 1'b0;
            end
            if ((state_q == RX_DATA) && ctr_hit) begin
                shreg_q <= {rxs, shreg_q[DATA_W-1:1]};
                bit_q   <= bit_q + 1'b1;
            end
            if ((state_q == RX_PARITY) && ctr_hit) begin
                perr_acc_q <= (rxs != par_bit(par_q, ^shreg_q));
            end
        end
    end

    // Output logic: frame result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done <= 1'b0;
            data <= '0;
            perr <= 1'b0;
            ferr <= 1'b0;
        end else begin
            done <= 1'b0;
            if ((state_q == RX_STOP) && ctr_hit && enable) begin
                done <= 1'b1;
                data <= shreg_q;
                perr <= perr_acc_q;
                ferr <= !rxs;
            end
        end
    end

endmodule

// File: rtl/uart_xcvr.sv
module uart_xcvr
    import uart_xcvr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic              mode_wr,
    input  logic [7:0]        mode_din,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_din,
    input  logic              rx_rd,
    input  logic              err_clr,
    input  logic              rxd,
    output logic              txd,
    output logic              tx_irq,
    output logic              rx_irq,
    output logic [DATA_W-1:0] rx_data,
    output logic              err_parity,
    output logic              err_frame,
    output logic              err_overrun
);
    logic    tx_en, rx_en, two_stop, rx_sup;
    parity_e par_mode;
    logic    tx_busy;
    logic    rx_done, rx_perr, rx_ferr;
    logic    rx_full_q;
    logic    ovr_now;
    logic    unused_mode_bits;

    assign unused_mode_bits = mode_din[3] ^ mode_din[0];

    // Mode register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en    <= 1'b0;
            rx_en    <= 1'b0;
            par_mode <= PAR_NONE;
            two_stop <= 1'b0;
            rx_sup   <= 1'b0;
        end else if (mode_wr) begin
            tx_en    <= mode_din[7];
            rx_en    <= mode_din[6];
            par_mode <= parity_e'(mode_din[5:4]);
            two_stop <= mode_din[2];
            rx_sup   <= mode_din[1];
        end
    end

    uart_tx #(.DATA_W(DATA_W), .OVS(OVS)) tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .enable   (tx_en),
        .wr       (tx_wr),
        .din      (tx_din),
        .par_mode (par_mode),
        .two_stop (two_stop),
        .txd      (txd),
        .done     (tx_irq),
        .busy     (tx_busy)
    );

    uart_rx #(.DATA_W(DATA_W), .OVS(OVS)) rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (baud_tick),
        .enable   (rx_en),
        .rxd_raw  (rxd),
        .par_mode (par_mode),
        .done     (rx_done),
        .data     (rx_data),
        .perr     (rx_perr),
        .ferr     (rx_ferr)
    );

    assign ovr_now = rx_done && rx_full_q;
    assign rx_irq  = rx_done && !(rx_sup && (rx_perr || rx_ferr || ovr_now));

    // Unread-byte tracking and sticky error flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_full_q   <= 1'b0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
        end else begin
            if (rx_done) begin
                rx_full_q <= 1'b1;
            end else if (rx_rd) begin
                rx_full_q <= 1'b0;
            end
            if (err_clr) begin
                err_parity  <= 1'b0;
                err_frame   <= 1'b0;
                err_overrun <= 1'b0;
            end
            if (rx_done) begin
                if (rx_perr) err_parity  <= 1'b1;
                if (rx_ferr) err_frame   <= 1'b1;
                if (ovr_now) err_overrun <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/uart_xcvr_chk.sv
module uart_xcvr_chk (
    input logic clk,
    input logic rst_n,
    input logic txd,
    input logic tx_busy,
    input logic tx_irq,
    input logic rx_irq,
    input logic rx_sup,
    input logic err_clr,
    input logic err_parity,
    input logic err_frame,
    input logic err_overrun
);
    // R1
    tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    // R3
    tx_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq);

    // R3
    tx_irq_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |-> txd);

    // R6
    rx_irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);

    // R11
    rx_sup_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_irq && rx_sup) |=> !$rose(err_parity) && !$rose(err_frame) && !$rose(err_overrun));

    // R12
    parity_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_parity && !err_clr) |=> err_parity);

    // R12
    frame_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frame && !err_clr) |=> err_frame);

    // R12
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_overrun && !err_clr) |=> err_overrun);

endmodule

bind uart_xcvr uart_xcvr_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .txd         (txd),
    .tx_busy     (tx_busy),
    .tx_irq      (tx_irq),
    .rx_irq      (rx_irq),
    .rx_sup      (rx_sup),
    .err_clr     (err_clr),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .err_overrun (err_overrun)
);

// File: tb/uart_xcvr_tb_top.sv
`timescale 1ns/1ps
module uart_xcvr_tb_top;
    localparam int TICK_DIV = 4;
    localparam int BIT      = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       mode_wr = 1'b0;
    logic [7:0] mode_din = '0;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_din = '0;
    logic       rx_rd = 1'b0;
    logic       err_clr = 1'b0;
    logic       rxd = 1'b1;
    logic       txd, tx_irq, rx_irq;
    logic [7:0] rx_data;
    logic       err_parity, err_frame, err_overrun;

    int errors = 0;
    int checks = 0;
    int tx_cnt = 0;
    int rx_cnt = 0;
    int tick_div = 0;

    always #2.5 clk = ~clk;

    uart_xcvr dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .mode_wr(mode_wr), .mode_din(mode_din),
        .tx_wr(tx_wr), .tx_din(tx_din), .rx_rd(rx_rd), .err_clr(err_clr),
        .rxd(rxd), .txd(txd), .tx_irq(tx_irq), .rx_irq(rx_irq),
        .rx_data(rx_data), .err_parity(err_parity), .err_frame(err_frame),
        .err_overrun(err_overrun)
    );

    always @(posedge clk) begin
        tick_div  <= (tick_div == TICK_DIV - 1) ? 0 : tick_div + 1;
        baud_tick <= (tick_div == TICK_DIV - 1);
        if (rst_n && tx_irq) tx_cnt <= tx_cnt + 1;
        if (rst_n && rx_irq) rx_cnt <= rx_cnt + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_mode(input logic [7:0] m);
        @(negedge clk); mode_din = m; mode_wr = 1'b1;
        @(negedge clk); mode_wr = 1'b0;
    endtask

    task automatic tx_write(input logic [7:0] b);
        @(negedge clk); tx_din = b; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    // Drive one frame on rxd; a low stop bit is held only past its centre.
    task automatic rx_send(input logic [7:0] d, input bit has_par, input bit pbit, input bit stop_ok);
        rxd = 1'b0; wait_clk(BIT);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i]; wait_clk(BIT);
        end
        if (has_par) begin
            rxd = pbit; wait_clk(BIT);
        end
        rxd = stop_ok;
        wait_clk(stop_ok ? BIT : 40);
        rxd = 1'b1; wait_clk(2 * BIT);
    endtask

    // Decode one frame from txd at bit centres.
    task automatic tx_capture(input bit has_par, input bit two,
                              output logic [7:0] d, output logic p,
                              output logic s1, output logic s2, output int irq_at_last);
        int w = 0;
        d = '0; p = 1'b0; s1 = 1'b0; s2 = 1'b1;
        while (txd !== 1'b0 && w < 5000) begin
            @(negedge clk); w++;
        end
        check(w < 5000, "R2 start bit seen", w, 0);
        wait_clk(BIT / 2);
        check(txd == 1'b0, "R2 start bit low", int'(txd), 0);
        for (int i = 0; i < 8; i++) begin
            wait_clk(BIT); d[i] = txd;
        end
        if (has_par) begin
            wait_clk(BIT); p = txd;
        end
        wait_clk(BIT); s1 = txd; irq_at_last = tx_cnt;
        if (two) begin
            wait_clk(BIT); s2 = txd; irq_at_last = tx_cnt;
        end
    endtask

    task automatic t_reset();
        check(txd == 1'b1, "R1 reset txd high", int'(txd), 1);
        check(!tx_irq && !rx_irq, "R3 reset irqs low", int'({tx_irq, rx_irq}), 0);
        check({err_parity, err_frame, err_overrun} == 3'b000, "R12 reset flags clear",
              int'({err_parity, err_frame, err_overrun}), 0);
    endtask

    task automatic t_tx_disabled();
        int c0 = tx_cnt;
        bit stayed = 1'b1;
        set_mode(8'h20);
        tx_write(8'h5A);
        for (int i = 0; i < 14 * BIT; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) stayed = 1'b0;
        end
        check(stayed, "R1 disabled write sends nothing", int'(stayed), 1);
        check(tx_cnt == c0, "R1 no tx_irq when disabled", tx_cnt - c0, 0);
    endtask

    task automatic t_tx_even();
        logic [7:0] d; logic p, s1, s2; int ia; int c0;
        set_mode(8'hA0);
        c0 = tx_cnt;
        tx_write(8'hB5);
        tx_capture(1'b1, 1'b0, d, p, s1, s2, ia);
        check(d == 8'hB5, "R2 even data", d, 8'hB5);
        check(p == 1'b1, "R2 even parity bit", int'(p), 1);
        check(s1 == 1'b1, "R2 stop high", int'(s1), 1);
        check(ia == c0, "R3 no irq during stop", ia - c0, 0);
        wait_clk(BIT);
        check(tx_cnt == c0 + 1, "R3 one tx_irq per frame", tx_cnt - c0, 1);
    endtask

    task automatic t_tx_odd_two_stop();
        logic [7:0] d; logic p, s1, s2; int ia; int c0;
        set_mode(8'hB4);
        c0 = tx_cnt;
        tx_write(8'h0F);
        tx_capture(1'b1, 1'b1, d, p, s1, s2, ia);
        check(d == 8'h0F, "R2 odd data", d, 8'h0F);
        check(p == 1'b1, "R2 odd parity bit", int'(p), 1);
        check(s1 && s2, "R2 two stop bits high", int'({s1, s2}), 3);
        check(ia == c0, "R3 no irq before second stop ends", ia - c0, 0);
        wait_clk(BIT);
        check(tx_cnt == c0 + 1, "R3 irq after second stop", tx_cnt - c0, 1);
    endtask

    task automatic t_tx_zero_hold();
        logic [7:0] d; logic p, s1, s2; int ia;
        set_mode(8'h90);
        tx_write(8'h13);
        wait_clk(3);
        tx_write(8'hC8);
        tx_capture(1'b1, 1'b0, d, p, s1, s2, ia);
        check(d == 8'h13, "R4 first frame data", d, 8'h13);
        check(p == 1'b0, "R2 zero parity bit", int'(p), 0);
        tx_capture(1'b1, 1'b0, d, p, s1, s2, ia);
        check(d == 8'hC8, "R4 held byte sent next", d, 8'hC8);
        wait_clk(2 * BIT);
    endtask

    task automatic t_rx_basic();
        int c0;
        set_mode(8'h40);
        pulse_rd();
        c0 = rx_cnt;
        rx_send(8'hA7, 1'b0, 1'b0, 1'b1);
        check(rx_data == 8'hA7, "R6 rx data", rx_data, 8'hA7);
        check(rx_cnt == c0 + 1, "R6 one rx_irq", rx_cnt - c0, 1);
        check({err_parity, err_frame, err_overrun} == 3'b000, "R8 clean frame no flags",
              int'({err_parity, err_frame, err_overrun}), 0);
        pulse_rd();
    endtask

    task automatic t_rx_parity();
        int c0;
        set_mode(8'h60);
        rx_send(8'h01, 1'b1, 1'b1, 1'b1);
        check(!err_parity, "R8 correct even parity accepted", int'(err_parity), 0);
        pulse_rd();
        set_mode(8'h50);
        c0 = rx_cnt;
        rx_send(8'h3C, 1'b1, 1'b1, 1'b1);
        check(err_parity, "R8 zero parity mismatch flagged", int'(err_parity), 1);
        check(rx_data == 8'h3C, "R11 errored byte stored", rx_data, 8'h3C);
        check(rx_cnt == c0 + 1, "R11 irq kept without suppress", rx_cnt - c0, 1);
        pulse_rd();
        rx_send(8'h66, 1'b1, 1'b0, 1'b1);
        check(err_parity, "R12 flag survives good frame", int'(err_parity), 1);
        pulse_rd();
        pulse_clr();
        check(!err_parity, "R12 err_clr clears flag", int'(err_parity), 0);
    endtask

    task automatic t_rx_frame_sup();
        int c0;
        set_mode(8'h46);
        c0 = rx_cnt;
        rx_send(8'h55, 1'b0, 1'b0, 1'b0);
        check(err_frame, "R9 low stop flagged", int'(err_frame), 1);
        check(rx_data == 8'h55, "R11 byte stored on framing error", rx_data, 8'h55);
        check(rx_cnt == c0, "R11 irq suppressed", rx_cnt - c0, 0);
        pulse_rd();
        pulse_clr();
    endtask

    task automatic t_rx_overrun();
        set_mode(8'h40);
        pulse_rd();
        rx_send(8'h11, 1'b0, 1'b0, 1'b1);
        check(!err_overrun, "R10 no overrun after read", int'(err_overrun), 0);
        rx_send(8'h22, 1'b0, 1'b0, 1'b1);
        check(err_overrun, "R10 overrun on unread byte", int'(err_overrun), 1);
        check(rx_data == 8'h22, "R10 newest byte kept", rx_data, 8'h22);
        pulse_rd();
        pulse_clr();
    endtask

    task automatic t_rx_glitch();
        int c0 = rx_cnt;
        rxd = 1'b0; wait_clk(12);
        rxd = 1'b1; wait_clk(12 * BIT);
        check(rx_cnt == c0, "R7 glitch gives no frame", rx_cnt - c0, 0);
        rx_send(8'h96, 1'b0, 1'b0, 1'b1);
        check(rx_data == 8'h96 && rx_cnt == c0 + 1, "R7 frame after glitch", rx_data, 8'h96);
        pulse_rd();
    endtask

    task automatic t_rx_disabled();
        int c0 = rx_cnt;
        set_mode(8'h00);
        rx_send(8'h3A, 1'b0, 1'b0, 1'b1);
        check(rx_cnt == c0, "R5 no irq when disabled", rx_cnt - c0, 0);
        check(rx_data == 8'h96, "R5 rx_data unchanged", rx_data, 8'h96);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        t_reset();
        t_tx_disabled();
        t_tx_even();
        t_tx_odd_two_stop();
        t_tx_zero_hold();
        t_rx_basic();
        t_rx_parity();
        t_rx_frame_sup();
        t_rx_overrun();
        t_rx_glitch();
        t_rx_disabled();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule